// File: doc/BRIEF.md
# Gated External Pulse Counter

This block measures how many pulses arrive on an asynchronous external clock line during a window set by an asynchronous gate line. Both lines are brought into the system clock domain through a synchroniser chain, and their falling edges are detected there. While the gate is high and software has set the run enable, each falling edge of the pulse line adds one to a 16-bit running count.

The falling edge of the gate closes the window. At that point the count is copied into a result register, and an interrupt flag is raised that also marks the result as valid. If the count wrapped during the window, an overflow flag is raised and the result reads as all ones. The running count then restarts from zero. Software reads the result and pulses the acknowledge input, which clears both flags. Windows that close while the flag is still pending are ignored, so an unread result is never overwritten.

The system clock has to run several times faster than the pulse rate, because every edge must be seen by the synchroniser chain.

Top module: `gated_pulse_counter`

## Requirements
- R1: The running count goes up by exactly one for each falling edge of the pulse input seen after synchronisation, and never by more than one per system clock.
- R2: The count holds its value whenever the gate is low or the run enable is low; pulses outside such a window do not appear in any result.
- R3: When the gate falls while the run enable is high and no interrupt is pending, the count of that window is captured into `result_o` and `irq_o` goes to 1. When the run enable is low, no capture takes place.
- R4: If the count wrapped past its maximum during the window, `ovf_o` is 1 and `result_o` is all ones. A count that reaches the maximum exactly without wrapping is reported as is, with `ovf_o` at 0.
- R5: Every capture resets the running count to zero, so the next window starts from zero.
- R6: `irq_o` and `ovf_o` stay set until `ack_i` is pulsed. The acknowledge clears both and leaves `result_o` unchanged.
- R7: While `irq_o` is set, closing gate windows produce no capture, `result_o` does not change, and no pulses are counted.
- R8: A pulse falling edge that arrives in the same system cycle as the gate falling edge is counted in the window being closed.
- R9: Reset (`rst_n` low, synchronous) clears the count, `result_o`, `ovf_o` and `irq_o`.
- R10: Each input reaches the edge detectors two system clocks after it changes (synchroniser depth 2). With a 1 MHz pulse, a 100 MHz system clock and a 400 µs window, the result is 400 within one count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_i | input | 1 | Asynchronous external pulse line; falling edges are counted |
| gate_i | input | 1 | Asynchronous gate; high opens the window, falling edge closes it |
| run_en_i | input | 1 | Software run enable that qualifies counting and capture |
| ack_i | input | 1 | Interrupt acknowledge; clears `irq_o` and `ovf_o` |
| result_o | output | CNT_W | Captured count of the last window (all ones after a wrap) |
| irq_o | output | 1 | Result-valid and interrupt request flag |
| ovf_o | output | 1 | The captured window wrapped the counter |

## Verification
The bench works at the wrap boundary. It checks a window that ends exactly at the maximum, which must not be flagged, and windows one or more counts past it. A design that tests the wrap at the wrong moment would either flag the first case or report the wrapped low value in the others. It drops the gate in the same cycle as a pulse falls: a design that gave capture priority over the increment would report one count short. It closes windows while the flag is pending and then checks that the old result survives and that the next window starts from zero. A design that overwrote the result, or kept counting behind the pending flag, would fail there. It also feeds pulses while the gate is low or the run enable is off. These must leave no trace, and a design that gated on only one of the two qualifiers would pick them up.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
   // Minimum synchroniser depth accepted by the block
   localparam int unsigned GPC_MIN_SYNC = 2;

   // How a window that wrapped the counter is reported
   typedef enum logic {
      WRAP_REPORT_ONES = 1'b0,
      WRAP_REPORT_RAW  = 1'b1
   } wrap_mode_e;
endpackage

// File: rtl/gpc_sync.sv
module gpc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic lvl_o
);
   import gpc_pkg::*;

   if (STAGES < GPC_MIN_SYNC) begin : g_bad_depth
      $error("gpc_sync: STAGES below minimum");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_i};
   end

   assign lvl_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpc_fall_det.sv
module gpc_fall_det (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic fall_o
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   assign fall_o = prev_q & ~lvl_i;

   // R1: a detected edge lasts one cycle, so one input edge counts once
   p_fall_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);
endmodule

// File: rtl/gpc_window_count.sv
module gpc_window_count #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] count_next_o,
   output logic             wrap_any_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 2) begin : g_bad_width
      $error("gpc_window_count: CNT_W too small");
   end

   logic [CNT_W-1:0] count_q;
   logic             wrapped_q;
   logic             wrap_now;

   assign wrap_now     = inc_i & (count_q == CNT_MAX);
   assign count_next_o = count_q + {{(CNT_W-1){1'b0}}, inc_i};
   assign wrap_any_o   = wrapped_q | wrap_now;
   assign count_o      = count_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q   <= '0;
         wrapped_q <= 1'b0;
      end else if (clr_i) begin
         count_q   <= '0;
         wrapped_q <= 1'b0;
      end else begin
         count_q   <= count_next_o;
         wrapped_q <= wrapped_q | wrap_now;
      end
   end

   // R2: no increment and no clear means the count holds
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !clr_i) |=> $stable(count_q));
   // R5: a capture restarts the window from zero
   p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (count_q == '0) && !wrapped_q);
endmodule

// File: rtl/gpc_result_latch.sv
module gpc_result_latch
   import gpc_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter wrap_mode_e  WRAP_MODE = WRAP_REPORT_ONES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_i,
   input  logic             ack_i,
   input  logic [CNT_W-1:0] total_i,
   input  logic             wrap_i,
   output logic [CNT_W-1:0] result_o,
   output logic             irq_o,
   output logic             ovf_o
);
   logic [CNT_W-1:0] report;

   if (WRAP_MODE == WRAP_REPORT_ONES) begin : g_sat
      assign report = wrap_i ? {CNT_W{1'b1}} : total_i;

      // R4: a flagged window always reads as all ones
      p_ovf_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
         ovf_o |-> (result_o == {CNT_W{1'b1}}));
   end else begin : g_raw
      assign report = total_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_o <= '0;
         irq_o    <= 1'b0;
         ovf_o    <= 1'b0;
      end else if (cap_i) begin
         result_o <= report;
         irq_o    <= 1'b1;
         ovf_o    <= wrap_i;
      end else if (ack_i) begin
         irq_o    <= 1'b0;
         ovf_o    <= 1'b0;
      end
   end

   // R6: the flag is sticky until acknowledged
   p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !ack_i) |=> irq_o);
   // R6: acknowledge clears both flags
   p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && ack_i) |=> (!irq_o && !ovf_o));
   // R7: a pending result is never overwritten
   p_result_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> $stable(result_o));
   // R9: reset leaves everything clear
   p_reset_clear_r9: assert property (@(posedge clk)
      !rst_n |=> (!irq_o && !ovf_o && result_o == '0));
endmodule

// File: rtl/gated_pulse_counter.sv
module gated_pulse_counter
   import gpc_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter wrap_mode_e  WRAP_MODE   = WRAP_REPORT_ONES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pulse_i,
   input  logic             gate_i,
   input  logic             run_en_i,
   input  logic             ack_i,
   output logic [CNT_W-1:0] result_o,
   output logic             irq_o,
   output logic             ovf_o
);
   localparam int unsigned N_IN  = 2;
   localparam int unsigned IDX_P = 0;
   localparam int unsigned IDX_G = 1;

   logic [N_IN-1:0] raw_in;
   logic [N_IN-1:0] lvl;
   logic [N_IN-1:0] fall;

   assign raw_in[IDX_P] = pulse_i;
   assign raw_in[IDX_G] = gate_i;

   for (genvar i = 0; i < N_IN; i++) begin : g_in
      gpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .async_i(raw_in[i]),
         .lvl_o  (lvl[i])
      );
      gpc_fall_det u_fall (
         .clk   (clk),
         .rst_n (rst_n),
         .lvl_i (lvl[i]),
         .fall_o(fall[i])
      );
   end

   logic             armed;
   logic             in_window;
   logic             inc;
   logic             cap;
   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] total;
   logic             wrap_any;

   // The closing cycle still belongs to the window, so a coincident pulse edge counts
   assign armed     = run_en_i & ~irq_o;
   assign in_window = lvl[IDX_G] | fall[IDX_G];
   assign inc       = armed & in_window & fall[IDX_P];
   assign cap       = armed & fall[IDX_G];

   gpc_window_count #(.CNT_W(CNT_W)) u_count (
      .clk         (clk),
      .rst_n       (rst_n),
      .inc_i       (inc),
      .clr_i       (cap),
      .count_o     (count),
      .count_next_o(total),
      .wrap_any_o  (wrap_any)
   );

   gpc_result_latch #(.CNT_W(CNT_W), .WRAP_MODE(WRAP_MODE)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_i   (cap),
      .ack_i   (ack_i),
      .total_i (total),
      .wrap_i  (wrap_any),
      .result_o(result_o),
      .irq_o   (irq_o),
      .ovf_o   (ovf_o)
   );

   // R7: nothing is counted while a result waits to be read
   p_no_count_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> $stable(count));
   // R2: with the run enable off the count holds
   p_run_off_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en_i && !ack_i) |=> $stable(count));
   // R3: a capture happens only on a closing gate
   p_cap_on_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(fall[IDX_G]));
endmodule

// File: tb/sim_gated_pulse_counter.sv
module sim_gated_pulse_counter;
   localparam int CW   = 10;
   localparam int MAXV = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pulse = 1'b0;
   logic gate = 1'b0;
   logic run_en = 1'b0;
   logic ack = 1'b0;
   logic [CW-1:0] result;
   logic irq;
   logic ovf;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   gated_pulse_counter #(.CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .pulse_i(pulse), .gate_i(gate),
      .run_en_i(run_en), .ack_i(ack),
      .result_o(result), .irq_o(irq), .ovf_o(ovf)
   );

   // columns: pre-pulses, window pulses, half period, run, exp irq, exp result, exp ovf
   localparam int NV = 9;
   localparam int TBL [NV][7] = '{
      '{0,    3,  2, 1, 1,    3, 0},   // R1 R3
      '{5,    7,  3, 1, 1,    7, 0},   // R2 pulses with gate low ignored
      '{0,    0,  2, 1, 1,    0, 0},   // R3 empty window
      '{0,    4,  2, 0, 0,    0, 0},   // R2 R3 run enable off
      '{0, 1023,  2, 1, 1, 1023, 0},   // R4 exact maximum
      '{0, 1024,  2, 1, 1, 1023, 1},   // R4 wrap by one
      '{0, 1030,  2, 1, 1, 1023, 1},   // R4 wrap further
      '{0,  400, 50, 1, 1,  400, 0},   // R10 1 MHz, 400 us
      '{0,   10,  2, 1, 1,   10, 0}    // R5 fresh start after wrap
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulses(input int n, input int half);
      for (int k = 0; k < n; k++) begin
         pulse = 1'b1;
         repeat (half) @(negedge clk);
         pulse = 1'b0;
         repeat (half) @(negedge clk);
      end
   endtask

   task automatic window(input int pre, input int n, input int half, input bit run);
      run_en = run;
      pulses(pre, half);
      gate = 1'b1;
      repeat (4) @(negedge clk);
      pulses(n, half);
      repeat (3) @(negedge clk);
      gate = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic do_ack();
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [CW-1:0] held;
      repeat (5) @(negedge clk);
      chk("R9 reset irq", int'(irq), 0);
      chk("R9 reset result", int'(result), 0);
      chk("R9 reset ovf", int'(ovf), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         window(TBL[v][0], TBL[v][1], TBL[v][2], TBL[v][3] != 0);
         chk($sformatf("R3 irq vec%0d", v), int'(irq), TBL[v][4]);
         if (TBL[v][4] != 0) begin
            chk($sformatf("R1 R4 result vec%0d", v), int'(result), TBL[v][5]);
            chk($sformatf("R4 ovf vec%0d", v), int'(ovf), TBL[v][6]);
            repeat (10) @(negedge clk);
            chk($sformatf("R6 sticky vec%0d", v), int'(irq), 1);
            do_ack();
            chk($sformatf("R6 ack irq vec%0d", v), int'(irq), 0);
            chk($sformatf("R6 ack ovf vec%0d", v), int'(ovf), 0);
            chk($sformatf("R6 ack result vec%0d", v), int'(result), TBL[v][5]);
         end
         run_en = 1'b1;
      end

      // R7: windows while pending are ignored and not counted
      window(0, 3, 2, 1'b1);
      chk("R7 first", int'(result), 3);
      window(0, 5, 2, 1'b1);
      chk("R7 result kept", int'(result), 3);
      chk("R7 irq kept", int'(irq), 1);
      do_ack();
      window(0, 2, 2, 1'b1);
      chk("R7 R5 no hidden count", int'(result), 2);
      do_ack();

      // R8: pulse falls in the same cycle as the gate
      gate = 1'b1;
      repeat (4) @(negedge clk);
      pulses(2, 2);
      pulse = 1'b1;
      repeat (2) @(negedge clk);
      pulse = 1'b0;
      gate  = 1'b0;
      repeat (6) @(negedge clk);
      chk("R8 coincident edge", int'(result), 3);
      do_ack();

      // R9: reset during a pending result and during a window
      window(0, 4, 2, 1'b1);
      held = result;
      chk("R9 pre", int'(held), 4);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 irq cleared", int'(irq), 0);
      chk("R9 result cleared", int'(result), 0);
      rst_n = 1'b1;
      gate = 1'b1;
      repeat (4) @(negedge clk);
      pulses(3, 2);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      pulses(2, 2);
      repeat (3) @(negedge clk);
      gate = 1'b0;
      repeat (6) @(negedge clk);
      chk("R9 count cleared", int'(result), 2);
      chk("R9 irq after", int'(irq), 1);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule